// File: doc/BRIEF.md
# Multi-Channel Compare Timer

A memory-mapped up-counting timer for a system bus. A clock-source selector picks one of seven tick-enable inputs. A programmable prescaler divides the selected ticks, and each divided tick advances a counter by one. Three compare channels watch the counter. Each match sets a sticky flag, and so does the wrap from all-ones back to zero. Software clears a flag by writing a one to its bit. A six-bit enable mask selects which flags raise the single level interrupt output.

There are two counting modes. In free-run mode the counter wraps at its full width. In restart mode the counter returns to zero on the tick after it equals the first compare value, so that value sets the period. Enabling the timer can either restart the count or resume from the held value. A software reset bit returns most of the block to its reset state while keeping the enable, clock and low-power control bits.

Top module: `cmp_timer`

## Requirements
- R1: After reset, control, prescaler, status, interrupt enable and counter read zero, all three compare registers read all-ones, and the interrupt output is low.
- R2: Registers sit at word indexes 0 control, 1 prescaler, 2 status, 3 interrupt enable, 4/5/6 compare 1/2/3, 7/8 capture 1/2 and 9 counter. The capture registers and every index from 10 upward read zero, and writes to them change nothing.
- R3: The counter advances once every (prescaler+1) ticks of the input chosen by control bits 8:6, where code k selects tick input k-1. Code 0 selects no input, and the counter then holds. A prescaler write restarts the division.
- R4: When control bit 0 (enable) goes from 0 to 1 while bit 1 (enable-mode) is set, the counter restarts from zero. With bit 1 clear it resumes from its held value. While bit 0 is clear the counter does not move.
- R5: In restart mode (control bit 9 clear), the tick after the counter equals compare 1 returns the counter to zero.
- R6: In restart mode, any write to compare 1 clears the counter to zero.
- R7: Writing status clears each flag whose bit in bits 5:0 of the write data is 1 and leaves the flags written with 0. A flag set in the same cycle wins over its clear.
- R8: In free-run mode (control bit 9 set) the counter wraps from all-ones to zero and sets the rollover flag, status bit 5.
- R9: Status bits 0, 1 and 2 are set on the tick where the counter becomes equal to compare 1, 2 or 3. Events that coincide on one count set all their flags together. The capture flags, bits 3 and 4, are never set.
- R10: A control write stores the data with bits 2, 4 and 10 to 14 forced to zero. A write with bit 15 set instead performs a soft reset. The soft reset keeps control bits 0, 1, 3, 5, 6-8, 16 and 17 from that write, clears every other control bit including bit 15, clears prescaler, status, interrupt enable and counter, and loads all compare registers with all-ones.
- R11: The interrupt output is high exactly when control bit 0 is set and status AND interrupt enable is nonzero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| tick_src_i | input | 7 | Tick-enable inputs, one per clock-source code 1..7 |
| bus_addr_i | input | ADDR_W | Word index of the register accessed |
| bus_we_i | input | 1 | Write strobe for one cycle |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data for bus_addr_i, combinational |
| irq_o | output | 1 | Level interrupt |

## Verification
The checker watches several rules on every cycle: the counter holds while the timer is disabled, the counter restarts after a compare-1 match in restart mode, a compare-1 write clears the counter, rollover sets its flag, a rising compare-1 flag matches the count, the software-reset bit never stays set, the interrupt stays low while the timer is disabled, and source code 0 gives no advance. Other properties need a whole scenario and only the bench's scenarios show them. These are the exact count after a known number of prescaled ticks, resume versus restart on enable, several flags set together on a shared count, write-one-to-clear, the full set of values a soft reset leaves, and ignored writes to capture and unmapped indexes.

// File: rtl/cmp_timer_pkg.sv
package cmp_timer_pkg;
  localparam int unsigned BUS_W  = 32;
  localparam int unsigned SRC_W  = 3;
  localparam int unsigned NUM_SRC = (1 << SRC_W) - 1;
  localparam int unsigned NCMP   = 3;
  localparam int unsigned NFLAG  = 6;
  localparam int unsigned NREG   = 10;

  // register word indexes
  localparam int unsigned REG_CTRL = 0;
  localparam int unsigned REG_PRE  = 1;
  localparam int unsigned REG_STAT = 2;
  localparam int unsigned REG_IEN  = 3;
  localparam int unsigned REG_CMP1 = 4;
  localparam int unsigned REG_CAP1 = 7;
  localparam int unsigned REG_CAP2 = 8;
  localparam int unsigned REG_CNT  = 9;

  // control bit positions
  localparam int unsigned CB_EN     = 0;
  localparam int unsigned CB_ENMOD  = 1;
  localparam int unsigned CB_SRC_LO = 6;
  localparam int unsigned CB_FRR    = 9;
  localparam int unsigned CB_SWR    = 15;

  localparam logic [BUS_W-1:0] CTRL_FORCE0 = 32'h0000_7C14;
  localparam logic [BUS_W-1:0] CTRL_KEEP   = 32'h0003_01EB;

  // flag bit positions (status and interrupt enable)
  localparam int unsigned FL_CMP1 = 0;
  localparam int unsigned FL_ROLL = 5;
endpackage

// File: rtl/ct_tick_div.sv
module ct_tick_div
  import cmp_timer_pkg::*;
#(
  parameter int unsigned PRE_W = 12
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               run_i,
  input  logic               clear_i,
  input  logic [SRC_W-1:0]   src_sel_i,
  input  logic [NUM_SRC-1:0] src_tick_i,
  input  logic [PRE_W-1:0]   pre_i,
  output logic               adv_o
);
  logic             tick_sel;
  logic [PRE_W-1:0] pdiv_q, pdiv_n;
  logic             pdiv_en;

  always_comb begin
    tick_sel = 1'b0;
    for (int i = 0; i < NUM_SRC; i++) begin
      if (src_sel_i == SRC_W'(i + 1)) tick_sel = src_tick_i[i];
    end
  end

  assign adv_o   = run_i && tick_sel && (pdiv_q >= pre_i);
  assign pdiv_en = clear_i || (run_i && tick_sel);

  always_comb begin
    if (clear_i)    pdiv_n = '0;
    else if (adv_o) pdiv_n = '0;
    else            pdiv_n = pdiv_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       pdiv_q <= '0;
    else if (pdiv_en) pdiv_q <= pdiv_n;
  end
endmodule

// File: rtl/ct_counter.sv
module ct_counter #(
  parameter int unsigned CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             adv_i,
  input  logic             clear_i,
  input  logic             free_run_i,
  input  logic [CNT_W-1:0] period_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic [CNT_W-1:0] cnt_nx_o,
  output logic             step_o,
  output logic             wrap_o
);
  logic [CNT_W-1:0] cnt_q;

  assign step_o = adv_i && !clear_i;
  assign wrap_o = step_o && (cnt_q == '1);

  always_comb begin
    if (clear_i)                               cnt_nx_o = '0;
    else if (!adv_i)                           cnt_nx_o = cnt_q;
    else if (!free_run_i && cnt_q == period_i) cnt_nx_o = '0;
    else                                       cnt_nx_o = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 cnt_q <= '0;
    else if (clear_i || adv_i)  cnt_q <= cnt_nx_o;
  end

  assign cnt_o = cnt_q;
endmodule

// File: rtl/ct_match.sv
module ct_match
  import cmp_timer_pkg::*;
#(
  parameter int unsigned CNT_W = 32
) (
  input  logic                       step_i,
  input  logic [CNT_W-1:0]           cnt_nx_i,
  input  logic [NCMP-1:0][CNT_W-1:0] cmp_i,
  output logic [NCMP-1:0]            hit_o
);
  for (genvar g = 0; g < NCMP; g++) begin : g_ch
    assign hit_o[g] = step_i && (cnt_nx_i == cmp_i[g]);
  end
endmodule

// File: rtl/cmp_timer.sv
module cmp_timer
  import cmp_timer_pkg::*;
#(
  parameter int unsigned CNT_W  = 32,
  parameter int unsigned PRE_W  = 12,
  parameter int unsigned ADDR_W = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] tick_src_i,
  input  logic [ADDR_W-1:0]  bus_addr_i,
  input  logic               bus_we_i,
  input  logic [BUS_W-1:0]   bus_wdata_i,
  output logic [BUS_W-1:0]   bus_rdata_o,
  output logic               irq_o
);
  logic [BUS_W-1:0]            ctrl_q, ctrl_n, ctrl_wval;
  logic [PRE_W-1:0]            pre_q, pre_n;
  logic [NFLAG-1:0]            stat_q, stat_n, stat_clr, stat_set;
  logic [NFLAG-1:0]            ien_q, ien_n;
  logic [NCMP-1:0][CNT_W-1:0]  cmp_q, cmp_n;
  logic [NREG-1:0]             wr_sel;
  logic                        soft_rst, en_restart, cnt_clear, pdiv_clear;
  logic                        tick_adv, cnt_step, cnt_wrap;
  logic [CNT_W-1:0]            cnt, cnt_nx;
  logic [NCMP-1:0]             cmp_hit;

  for (genvar g = 0; g < NREG; g++) begin : g_dec
    assign wr_sel[g] = bus_we_i && (bus_addr_i == ADDR_W'(g));
  end

  assign ctrl_wval  = bus_wdata_i & ~CTRL_FORCE0;
  assign soft_rst   = wr_sel[REG_CTRL] && bus_wdata_i[CB_SWR];
  assign en_restart = wr_sel[REG_CTRL] && !soft_rst && !ctrl_q[CB_EN]
                      && ctrl_wval[CB_EN] && ctrl_wval[CB_ENMOD];
  assign cnt_clear  = soft_rst || en_restart
                      || (wr_sel[REG_CMP1] && !ctrl_q[CB_FRR]);
  assign pdiv_clear = cnt_clear || wr_sel[REG_PRE];

  ct_tick_div #(.PRE_W(PRE_W)) u_div (
    .clk        (clk),
    .rst_n      (rst_n),
    .run_i      (ctrl_q[CB_EN]),
    .clear_i    (pdiv_clear),
    .src_sel_i  (ctrl_q[CB_SRC_LO +: SRC_W]),
    .src_tick_i (tick_src_i),
    .pre_i      (pre_q),
    .adv_o      (tick_adv)
  );

  ct_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk        (clk),
    .rst_n      (rst_n),
    .adv_i      (tick_adv),
    .clear_i    (cnt_clear),
    .free_run_i (ctrl_q[CB_FRR]),
    .period_i   (cmp_q[0]),
    .cnt_o      (cnt),
    .cnt_nx_o   (cnt_nx),
    .step_o     (cnt_step),
    .wrap_o     (cnt_wrap)
  );

  ct_match #(.CNT_W(CNT_W)) u_match (
    .step_i   (cnt_step),
    .cnt_nx_i (cnt_nx),
    .cmp_i    (cmp_q),
    .hit_o    (cmp_hit)
  );

  // flags: compares in the low bits, capture bits idle, rollover on top
  assign stat_set = {cnt_wrap, 2'b00, cmp_hit};
  assign stat_clr = wr_sel[REG_STAT] ? bus_wdata_i[NFLAG-1:0] : '0;

  always_comb begin
    ctrl_n = ctrl_q;
    pre_n  = pre_q;
    ien_n  = ien_q;
    cmp_n  = cmp_q;
    stat_n = (stat_q & ~stat_clr) | stat_set;
    if (soft_rst) begin
      ctrl_n = ctrl_wval & CTRL_KEEP;
      pre_n  = '0;
      ien_n  = '0;
      stat_n = '0;
      for (int i = 0; i < NCMP; i++) cmp_n[i] = '1;
    end else begin
      if (wr_sel[REG_CTRL]) ctrl_n = ctrl_wval;
      if (wr_sel[REG_PRE])  pre_n  = bus_wdata_i[PRE_W-1:0];
      if (wr_sel[REG_IEN])  ien_n  = bus_wdata_i[NFLAG-1:0];
      for (int i = 0; i < NCMP; i++) begin
        if (wr_sel[REG_CMP1 + i]) cmp_n[i] = bus_wdata_i[CNT_W-1:0];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      pre_q  <= '0;
      stat_q <= '0;
      ien_q  <= '0;
      for (int i = 0; i < NCMP; i++) cmp_q[i] <= '1;
    end else begin
      ctrl_q <= ctrl_n;
      pre_q  <= pre_n;
      stat_q <= stat_n;
      ien_q  <= ien_n;
      cmp_q  <= cmp_n;
    end
  end

  always_comb begin
    bus_rdata_o = '0;
    if (bus_addr_i == ADDR_W'(REG_CTRL))      bus_rdata_o = ctrl_q;
    else if (bus_addr_i == ADDR_W'(REG_PRE))  bus_rdata_o = BUS_W'(pre_q);
    else if (bus_addr_i == ADDR_W'(REG_STAT)) bus_rdata_o = BUS_W'(stat_q);
    else if (bus_addr_i == ADDR_W'(REG_IEN))  bus_rdata_o = BUS_W'(ien_q);
    else if (bus_addr_i == ADDR_W'(REG_CNT))  bus_rdata_o = BUS_W'(cnt);
    else begin
      for (int i = 0; i < NCMP; i++) begin
        if (bus_addr_i == ADDR_W'(REG_CMP1 + i)) bus_rdata_o = BUS_W'(cmp_q[i]);
      end
    end
  end

  assign irq_o = ctrl_q[CB_EN] && |(stat_q & ien_q);
endmodule

// File: rtl/cmp_timer_chk.sv
module cmp_timer_chk
  import cmp_timer_pkg::*;
#(
  parameter int unsigned CNT_W  = 32,
  parameter int unsigned ADDR_W = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_we,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [BUS_W-1:0]  ctrl,
  input logic [NFLAG-1:0]  stat,
  input logic [CNT_W-1:0]  cnt,
  input logic [CNT_W-1:0]  cmp1,
  input logic              adv,
  input logic              irq
);
  // R4
  cnt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctrl[CB_EN] && !bus_we) |=> $stable(cnt));

  // R5
  restart_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && !ctrl[CB_FRR] && cnt == cmp1 && !bus_we) |=> (cnt == '0));

  // R6
  cmp1_wr_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && bus_addr == ADDR_W'(REG_CMP1) && !ctrl[CB_FRR]) |=> (cnt == '0));

  // R8
  rollover_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && cnt == '1 && !bus_we) |=> stat[FL_ROLL]);

  // R9
  cmp1_flag_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(stat[FL_CMP1]) && !$past(bus_we)) |-> (cnt == cmp1));

  // R10
  swr_self_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && bus_addr == ADDR_W'(REG_CTRL)) |=> !ctrl[CB_SWR]);

  // R11
  irq_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl[CB_EN] |-> !irq);

  // R3
  no_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl[CB_SRC_LO +: SRC_W] == '0) |-> !adv);
endmodule

bind cmp_timer cmp_timer_chk #(.CNT_W(CNT_W), .ADDR_W(ADDR_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .bus_we   (bus_we_i),
  .bus_addr (bus_addr_i),
  .ctrl     (ctrl_q),
  .stat     (stat_q),
  .cnt      (cnt),
  .cmp1     (cmp_q[0]),
  .adv      (tick_adv),
  .irq      (irq_o)
);

// File: tb/cmp_timer_tb.sv
module cmp_timer_tb;
  localparam int CLK_PERIOD = 10;
  localparam int CNT_W = 8;
  localparam int ADDR_W = 4;

  logic        clk;
  logic        rst_n;
  logic [6:0]  tick_src;
  logic [3:0]  bus_addr;
  logic        bus_we;
  logic [31:0] bus_wdata;
  logic [31:0] bus_rdata;
  logic        irq;

  typedef struct {
    bit          is_irq;
    logic [3:0]  addr;
    logic [31:0] exp;
    string       tag;
  } item_t;

  item_t sb_q[$];
  int n_checks = 0;
  int n_fail = 0;
  bit done = 0;

  cmp_timer #(.CNT_W(CNT_W), .PRE_W(12), .ADDR_W(ADDR_W)) u_dut (
    .clk         (clk),
    .rst_n       (rst_n),
    .tick_src_i  (tick_src),
    .bus_addr_i  (bus_addr),
    .bus_we_i    (bus_we),
    .bus_wdata_i (bus_wdata),
    .bus_rdata_o (bus_rdata),
    .irq_o       (irq)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  // monitor: samples a quarter period after the falling edge
  always begin
    @(negedge clk);
    #(CLK_PERIOD / 4);
    while (sb_q.size() > 0) begin
      item_t it;
      logic [31:0] act;
      it = sb_q.pop_front();
      act = it.is_irq ? {31'b0, irq} : bus_rdata;
      n_checks++;
      if (act !== it.exp) begin
        n_fail++;
        $display("FAIL %s addr=%0d actual=0x%08h expected=0x%08h",
                 it.tag, it.addr, act, it.exp);
      end
    end
  end

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic chk(input logic [3:0] a, input logic [31:0] e, input string tag);
    item_t it;
    @(negedge clk);
    bus_we = 1'b0; bus_addr = a;
    it.is_irq = 1'b0; it.addr = a; it.exp = e; it.tag = tag;
    sb_q.push_back(it);
  endtask

  task automatic chk_irq(input logic e, input string tag);
    item_t it;
    @(negedge clk);
    bus_we = 1'b0;
    it.is_irq = 1'b1; it.addr = 4'd0; it.exp = {31'b0, e}; it.tag = tag;
    sb_q.push_back(it);
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: run did not finish");
      summary();
    end
  end

  initial begin
    rst_n = 1'b0; tick_src = 7'b0000001;
    bus_addr = '0; bus_we = 1'b0; bus_wdata = '0;
    idle(3);
    rst_n = 1'b1;

    // R1 reset values
    chk(4'd0, 32'h0, "R1 ctrl");
    chk(4'd1, 32'h0, "R1 prescaler");
    chk(4'd2, 32'h0, "R1 status");
    chk(4'd3, 32'h0, "R1 irq enable");
    chk(4'd4, 32'hFF, "R1 compare1");
    chk(4'd5, 32'hFF, "R1 compare2");
    chk(4'd6, 32'hFF, "R1 compare3");
    chk(4'd9, 32'h0, "R1 counter");
    chk_irq(1'b0, "R1 irq");

    // R10 forced-zero bits on a plain control write
    wr(4'd0, 32'h0001_7C1C);
    chk(4'd0, 32'h0001_0008, "R10 ctrl mask");
    wr(4'd0, 32'h0);

    // R3 prescale by 4: 8 ticks give 2 advances
    wr(4'd1, 32'd3);
    wr(4'd0, 32'h43);
    idle(6);
    wr(4'd0, 32'h42);
    chk(4'd9, 32'd2, "R3 prescaled count");
    chk(4'd1, 32'd3, "R3 prescaler readback");

    // R3 source code 0: no advance; R4 resume without enable-mode
    wr(4'd0, 32'h01);
    idle(5);
    wr(4'd0, 32'h00);
    chk(4'd9, 32'd2, "R3 no source holds");

    // R4 resume from held value, then restart with enable-mode
    wr(4'd1, 32'd0);
    wr(4'd0, 32'h41);
    wr(4'd0, 32'h40);
    chk(4'd9, 32'd4, "R4 resume");
    wr(4'd0, 32'h43);
    wr(4'd0, 32'h42);
    chk(4'd9, 32'd2, "R4 restart on enable");

    // R5 restart mode period 6, R11 irq while enabled
    wr(4'd4, 32'd5);
    wr(4'd3, 32'h01);
    wr(4'd0, 32'h43);
    idle(4);
    chk_irq(1'b1, "R11 irq on compare1 flag");
    wr(4'd0, 32'h42);
    chk(4'd9, 32'd1, "R5 restart wrap");
    chk(4'd2, 32'h01, "R9 compare1 flag");
    chk_irq(1'b0, "R11 irq gated by enable");

    // R6 compare1 write clears counter in restart mode
    wr(4'd4, 32'd5);
    chk(4'd9, 32'd0, "R6 compare1 write clear");
    chk(4'd4, 32'd5, "R2 compare1 readback");

    // R7 write-one-to-clear
    wr(4'd2, 32'h3E);
    chk(4'd2, 32'h01, "R7 zero bits keep flag");
    wr(4'd2, 32'h01);
    chk(4'd2, 32'h00, "R7 one clears flag");

    // R8 free-run wrap; R9 compares 2 and 3 coincide at 0xFF
    wr(4'd3, 32'h20);
    wr(4'd0, 32'h243);
    idle(255);
    wr(4'd0, 32'h242);
    chk(4'd9, 32'd1, "R8 free-run wrap count");
    chk(4'd2, 32'h27, "R8 R9 rollover and coincident flags");
    chk_irq(1'b0, "R11 disabled");
    wr(4'd0, 32'h241);
    chk_irq(1'b1, "R11 rollover irq");
    wr(4'd0, 32'h240);

    // R10 soft reset
    wr(4'd1, 32'd7);
    wr(4'd5, 32'd9);
    wr(4'd0, 32'h0001_8243);
    chk(4'd0, 32'h0001_0043, "R10 soft reset ctrl");
    chk(4'd1, 32'h0, "R10 soft reset prescaler");
    chk(4'd2, 32'h0, "R10 soft reset status");
    chk(4'd3, 32'h0, "R10 soft reset irq enable");
    chk(4'd4, 32'hFF, "R10 soft reset compare1");
    chk(4'd5, 32'hFF, "R10 soft reset compare2");
    wr(4'd0, 32'h0);

    // R2 capture and unmapped indexes
    wr(4'd12, 32'hFFFF_FFFF);
    wr(4'd7, 32'h1234);
    wr(4'd8, 32'h5678);
    chk(4'd7, 32'h0, "R2 capture1 zero");
    chk(4'd8, 32'h0, "R2 capture2 zero");
    chk(4'd12, 32'h0, "R2 unmapped zero");
    chk(4'd10, 32'h0, "R2 unmapped 10 zero");
    chk(4'd0, 32'h0, "R2 ctrl untouched");
    chk(4'd3, 32'h0, "R2 irq enable untouched");

    idle(2);
    done = 1;
    summary();
  end
endmodule